// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the address-strobe line of a microcontroller bus. It puts the attached memory and logic subsystem into a low-power state once the strobe has been quiet for a fixed number of reference-clock periods. A small saturating counter runs on the reference clock and counts idle periods. The reference clock is never gated by this block, so the count keeps running whatever software has chosen to block. When the count reaches its terminal value, the power-down flag rises. While the flag is high, the block isolates the address/data bus from memory and logic, requests memory standby and tri-states the peripheral port. The subsystem wakes on any of three independent events: a new edge on the strobe, a low level on the active-low chip select, or reset.

Software controls the block through two byte-wide mode registers, reached over a simple write port with read-back. Register 0 holds the enable bit and two input-block bits. Register 2 holds five more input-block bits. Each block bit stops one control input (or the shared clock line) from reaching the downstream logic, but only while the subsystem is powered down. Software sets the block bits before the bus goes idle. When the subsystem is awake, every input passes through unchanged.

Top module: `bus_idle_pdn`

## Requirements
- R1: When `rst` is sampled high, the following happens at that clock edge: both mode registers read back 0, `pdn` is low, and `ctl_gated` equals `ctl_in`.
- R2: A write takes effect at the clock edge where `reg_we` is high. With `reg_sel`=0, the write reaches mode register 0: bit 1 is the enable, and bits 4 and 5 are block bits 0 and 1. With `reg_sel`=1, the write reaches mode register 2: bits 2 to 6 are block bits 2 to 6. Unimplemented bits read as 0. `reg_rdata` shows the selected register combinationally.
- R3: Both `strobe_in` and `csel_n` pass through two-flop synchronisers. With the block enabled, suppose edge k is the first clock edge that samples the final strobe level. Then `pdn` is still low after edge k+16 and goes high after edge k+17, which means 15 idle periods counted by the 4-bit counter.
- R4: The counter saturates. Once `pdn` is high, it stays high for as long as the strobe is idle, `csel_n` is high and the enable bit is set.
- R5: If edge k samples a changed `strobe_in` level, `pdn` is low after edge k+2 and the idle count restarts from zero.
- R6: If edge k samples `csel_n` low, `pdn` is low after edge k+2. No power-down occurs while `csel_n` stays low.
- R7: Raising `rst` while powered down wakes the block at that edge and clears both mode registers.
- R8: Writing 0 to the enable bit while powered down drops `pdn` right after the write edge. A later re-enable needs a full new idle interval.
- R9: `bus_iso`, `mem_stby` and `periph_hiz` are high exactly when `pdn` is high.
- R10: The gating rule is `ctl_gated[i] = ctl_in[i] & ~(block[i] & pdn)`. Index 0 is the shared clock line. Setting block bits, including the clock bit, does not delay or prevent power-down.
- R11: With the enable bit at 0, `pdn` never rises, however long the strobe is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the idle counter (never gated) |
| rst | input | 1 | Synchronous active-high reset, also a wake source |
| strobe_in | input | 1 | Address strobe from the bus, asynchronous |
| csel_n | input | 1 | Active-low chip select, asynchronous |
| reg_we | input | 1 | Mode register write strobe |
| reg_sel | input | 1 | 0 selects mode register 0, 1 selects mode register 2 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read-back of the selected mode register |
| ctl_in | input | 7 | Blockable inputs; bit 0 is the shared clock line |
| ctl_gated | output | 7 | Copies of `ctl_in` after blocking |
| pdn | output | 1 | Power-down flag |
| bus_iso | output | 1 | Cuts the address/data bus off from memory and logic |
| mem_stby | output | 1 | Memory standby request |
| periph_hiz | output | 1 | Tri-state enable for the peripheral port |

## Verification
The bench goes after the exact edge at which `pdn` rises. A counter that is off by one, or a synchroniser with the wrong depth, shifts that edge, and the bench samples the cycles on both sides of it. It then holds the bus idle well past the terminal count. A counter that wraps instead of saturating would briefly drop `pdn`. Each wake source is fired on its own: a strobe edge, a chip-select low and reset. It also clears the enable bit while powered down, which a design that only clears the counter would miss by one cycle. Block bits are checked both awake and asleep, including the clock-line bit. A gate that ignored `pdn`, or a bit map in the wrong order, shows up directly on `ctl_gated`.

// File: rtl/apd_pkg.sv
package apd_pkg;

    localparam int CNT_W      = 4;
    localparam int REG_W      = 8;
    localparam int NBLK       = 7;
    localparam int EN_POS     = 1;
    localparam int R0_BLK_LO  = 4;
    localparam int R0_NBLK    = 2;
    localparam int R2_BLK_LO  = 2;
    localparam int R2_NBLK    = NBLK - R0_NBLK;

    typedef struct packed {
        logic            en;
        logic [NBLK-1:0] blk;
    } apd_mode_t;

    typedef struct packed {
        logic act;
        logic sel;
    } apd_wake_t;

    function automatic logic [REG_W-1:0] pack_r0(input apd_mode_t m);
        logic [REG_W-1:0] v;
        v = '0;
        v[EN_POS] = m.en;
        for (int i = 0; i < R0_NBLK; i++) v[R0_BLK_LO+i] = m.blk[i];
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_r2(input apd_mode_t m);
        logic [REG_W-1:0] v;
        v = '0;
        for (int i = 0; i < R2_NBLK; i++) v[R2_BLK_LO+i] = m.blk[R0_NBLK+i];
        return v;
    endfunction

endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/apd_mode_regs.sv
module apd_mode_regs
    import apd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output apd_mode_t        mode
);
    apd_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (we) begin
            if (!sel) begin
                mode_q.en <= wdata[EN_POS];
                for (int i = 0; i < R0_NBLK; i++)
                    mode_q.blk[i] <= wdata[R0_BLK_LO+i];
            end else begin
                for (int i = 0; i < R2_NBLK; i++)
                    mode_q.blk[R0_NBLK+i] <= wdata[R2_BLK_LO+i];
            end
        end
    end

    assign rdata = sel ? pack_r2(mode_q) : pack_r0(mode_q);
    assign mode  = mode_q;
endmodule

// File: rtl/apd_idle_timer.sv
module apd_idle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             strobe_s,
    input  logic             csel_n_s,
    output logic             wake,
    output logic [CNT_W-1:0] cnt,
    output logic             pdn
);
    import apd_pkg::apd_wake_t;

    localparam logic [CNT_W-1:0] LIM = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             prev_q;
    apd_wake_t        wk;

    assign wk.act = strobe_s ^ prev_q;
    assign wk.sel = ~csel_n_s;
    assign wake   = wk.act | wk.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= strobe_s;
            if (!en || wake)     cnt_q <= '0;
            else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
    assign pdn = en && (cnt_q == LIM);
endmodule

// File: rtl/apd_gate.sv
module apd_gate #(
    parameter int N = 7
) (
    input  logic [N-1:0] din,
    input  logic [N-1:0] blk,
    input  logic         pdn,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign dout[i] = din[i] & ~(blk[i] & pdn);
    end
endmodule

// File: rtl/bus_idle_pdn.sv
module bus_idle_pdn
    import apd_pkg::*;
#(
    parameter int IDLE_W = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_in,
    input  logic             csel_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NBLK-1:0]  ctl_in,
    output logic [NBLK-1:0]  ctl_gated,
    output logic             pdn,
    output logic             bus_iso,
    output logic             mem_stby,
    output logic             periph_hiz
);
    apd_mode_t         mode;
    logic              strobe_s;
    logic              csel_n_s;
    logic              wake;
    logic [IDLE_W-1:0] cnt;
    logic              pdn_w;

    apd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_stb (
        .clk(clk), .rst(rst), .d(strobe_in), .q(strobe_s)
    );

    apd_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d(csel_n), .q(csel_n_s)
    );

    apd_mode_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .mode(mode)
    );

    apd_idle_timer #(.CNT_W(IDLE_W)) u_timer (
        .clk(clk), .rst(rst), .en(mode.en), .strobe_s(strobe_s),
        .csel_n_s(csel_n_s), .wake(wake), .cnt(cnt), .pdn(pdn_w)
    );

    apd_gate #(.N(NBLK)) u_gate (
        .din(ctl_in), .blk(mode.blk), .pdn(pdn_w), .dout(ctl_gated)
    );

    assign pdn        = pdn_w;
    assign bus_iso    = pdn_w;
    assign mem_stby   = pdn_w;
    assign periph_hiz = pdn_w;
endmodule

// File: rtl/apd_checker.sv
module apd_checker #(
    parameter int CNT_W = 4,
    parameter int N     = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             csel_n_s,
    input logic             wake,
    input logic [CNT_W-1:0] cnt,
    input logic             pdn,
    input logic             bus_iso,
    input logic             mem_stby,
    input logic             periph_hiz,
    input logic [N-1:0]     ctl_in,
    input logic [N-1:0]     ctl_gated
);
    localparam logic [CNT_W-1:0] LIM    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIM_M1 = LIM - 1'b1;

    assert_rise_after_count_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pdn) |-> ($past(cnt) == LIM_M1));

    assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt == LIM && en && !wake) |=> (cnt == LIM));

    assert_wake_clears_R5: assert property (@(posedge clk) disable iff (rst)
        wake |=> (cnt == '0 && !pdn));

    assert_cs_holds_awake_R6: assert property (@(posedge clk) disable iff (rst)
        !csel_n_s |=> !pdn);

    assert_port_class_R9: assert property (@(posedge clk) disable iff (rst)
        pdn |-> (bus_iso && mem_stby && periph_hiz));

    assert_pass_when_awake_R10: assert property (@(posedge clk) disable iff (rst)
        !pdn |-> (ctl_gated == ctl_in));

    assert_off_when_disabled_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pdn);
endmodule

bind bus_idle_pdn apd_checker #(.CNT_W(IDLE_W), .N(apd_pkg::NBLK)) u_chk (
    .clk(clk), .rst(rst), .en(mode.en), .csel_n_s(csel_n_s), .wake(wake),
    .cnt(cnt), .pdn(pdn), .bus_iso(bus_iso), .mem_stby(mem_stby),
    .periph_hiz(periph_hiz), .ctl_in(ctl_in), .ctl_gated(ctl_gated)
);

// File: tb/sim_bus_idle_pdn.sv
`timescale 1ns/1ps
module sim_bus_idle_pdn;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_in = 1'b0;
    logic       csel_n = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] ctl_in = 7'h55;
    logic [6:0] ctl_gated;
    logic       pdn, bus_iso, mem_stby, periph_hiz;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_idle_pdn u0 (
        .clk(clk), .rst(rst), .strobe_in(strobe_in), .csel_n(csel_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ctl_in(ctl_in), .ctl_gated(ctl_gated),
        .pdn(pdn), .bus_iso(bus_iso), .mem_stby(mem_stby), .periph_hiz(periph_hiz)
    );

    // behavioural reference model
    bit   stb_hist[$];
    bit   cs_hist[$];
    bit   m_en = 0;
    bit [6:0] m_blk = '0;
    int   m_idle = 0;

    function automatic bit exp_pdn();
        return m_en && (m_idle == 15);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            stb_hist = '{0, 0, 0};
            cs_hist  = '{1, 1, 1};
            m_en = 0; m_blk = '0; m_idle = 0;
        end else begin
            bit act, sel;
            act = stb_hist[stb_hist.size()-2] != stb_hist[stb_hist.size()-3];
            sel = !cs_hist[cs_hist.size()-2];
            if (!m_en || act || sel) m_idle = 0;
            else if (m_idle < 15) m_idle++;
            if (reg_we) begin
                if (!reg_sel) begin
                    m_en = reg_wdata[1];
                    m_blk[1:0] = reg_wdata[5:4];
                end else begin
                    m_blk[6:2] = reg_wdata[6:2];
                end
            end
            stb_hist.push_back(strobe_in);
            cs_hist.push_back(csel_n);
            if (stb_hist.size() > 4) void'(stb_hist.pop_front());
            if (cs_hist.size() > 4) void'(cs_hist.pop_front());
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] er;
            logic [6:0] eg;
            bit ep;
            ep = exp_pdn();
            er = reg_sel ? {1'b0, m_blk[6:2], 2'b00}
                         : {2'b00, m_blk[1:0], 2'b00, m_en, 1'b0};
            eg = ctl_in & ~(m_blk & {7{ep}});
            check(pdn == ep, "R3", "model pdn", {7'b0, pdn}, {7'b0, ep});
            check(reg_rdata == er, "R2", "model rdata", reg_rdata, er);
            check(ctl_gated == eg, "R10", "model gated", {1'b0, ctl_gated}, {1'b0, eg});
            check({bus_iso, mem_stby, periph_hiz} == {3{ep}}, "R9", "port class",
                  {5'b0, bus_iso, mem_stby, periph_hiz}, {5'b0, {3{ep}}});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        tick(1);
        reg_we = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic toggle(input int n);
        for (int i = 0; i < n; i++) begin
            strobe_in = ~strobe_in;
            tick(1);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        tick(3);
        // R1: reset state
        check(pdn == 0 && ctl_gated == ctl_in, "R1", "reset outputs",
              {7'b0, pdn}, 8'h00);
        check(reg_rdata == 8'h00, "R1", "reset rdata", reg_rdata, 8'h00);
        rst = 1'b0;
        tick(2);

        // R11: idle with unit disabled
        tick(40);
        check(pdn == 0, "R11", "disabled idle", {7'b0, pdn}, 8'h00);

        // R2: register map and read-back
        wr(0, 8'hFF);
        reg_sel = 0; #0.1;
        check(reg_rdata == 8'h32, "R2", "reg0 readback", reg_rdata, 8'h32);
        wr(1, 8'hFF);
        reg_sel = 1; #0.1;
        check(reg_rdata == 8'h7C, "R2", "reg2 readback", reg_rdata, 8'h7C);
        reg_sel = 0;
        wr(1, 8'h00);
        wr(0, 8'h02);

        // R3: exact power-down edge
        toggle(5);
        tick(16);
        check(pdn == 0, "R3", "one before limit", {7'b0, pdn}, 8'h00);
        tick(1);
        check(pdn == 1, "R3", "at limit", {7'b0, pdn}, 8'h01);
        check(bus_iso && mem_stby && periph_hiz, "R9", "asleep outputs",
              {5'b0, bus_iso, mem_stby, periph_hiz}, 8'h07);

        // R4: saturation
        tick(60);
        check(pdn == 1, "R4", "held while idle", {7'b0, pdn}, 8'h01);

        // R5: strobe edge wakes
        toggle(1);
        tick(1);
        check(pdn == 1, "R5", "before wake", {7'b0, pdn}, 8'h01);
        tick(1);
        check(pdn == 0, "R5", "strobe wake", {7'b0, pdn}, 8'h00);
        tick(30);

        // R6: chip select wakes and holds awake
        csel_n = 1'b0;
        tick(2);
        check(pdn == 1, "R6", "before cs wake", {7'b0, pdn}, 8'h01);
        tick(1);
        check(pdn == 0, "R6", "cs wake", {7'b0, pdn}, 8'h00);
        tick(40);
        check(pdn == 0, "R6", "cs held low", {7'b0, pdn}, 8'h00);
        csel_n = 1'b1;
        tick(30);

        // R8: clearing enable while asleep
        check(pdn == 1, "R8", "asleep before disable", {7'b0, pdn}, 8'h01);
        wr(0, 8'h00);
        check(pdn == 0, "R8", "disable drops pdn", {7'b0, pdn}, 8'h00);
        wr(0, 8'h02);
        tick(10);
        check(pdn == 0, "R8", "re-enable restarts count", {7'b0, pdn}, 8'h00);
        tick(20);

        // R10: blocking, clock bit included, does not stop the count
        wr(0, 8'h32);
        wr(1, 8'h7C);
        toggle(3);
        check(ctl_gated == 7'h55, "R10", "awake pass", {1'b0, ctl_gated}, 8'h55);
        tick(20);
        check(pdn == 1, "R10", "blocked clock still idles", {7'b0, pdn}, 8'h01);
        check(ctl_gated == 7'h00, "R10", "all blocked", {1'b0, ctl_gated}, 8'h00);
        wr(1, 8'h04);
        wr(0, 8'h02);
        ctl_in = 7'h7F; #0.1;
        check(ctl_gated == 7'h7B, "R10", "single block lane2", {1'b0, ctl_gated}, 8'h7B);

        // R7: reset wakes and clears registers
        rst = 1'b1;
        tick(1);
        check(pdn == 0, "R7", "reset wake", {7'b0, pdn}, 8'h00);
        check(reg_rdata == 8'h00, "R7", "reset clears reg", reg_rdata, 8'h00);
        rst = 1'b0;
        tick(30);
        check(pdn == 0, "R7", "stays awake after reset", {7'b0, pdn}, 8'h00);

        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule